// File: doc/BRIEF.md
# Serial One-Time-Programmable Fuse Word Writer

This block burns one 32-bit word at a time into a one-time-programmable fuse array. Software first loads the word address into the control register. In the same write it loads a 16-bit arming key into the upper half of that register. A write to the data register then starts the burn. The block captures the address in an internal copy and reads the word's present fuse contents. It removes from the request any bit that is already blown. It then shifts the data out least significant bit first, driving one program strobe for each bit that still needs burning. Once the busy flag drops, a settle gap holds off further requests.

The register port is a simple single-cycle write bus with a combinational read. It has five word slots. Slot 0 is the control register. Slots 1 and 2 are set and clear aliases of it. Slot 3 is the timing register and slot 4 is the data register. On the fuse side the block provides a latched word address, a bit position, a bit value, a program strobe and a read request. The array returns the selected word through a read-back input. A lock-mask input marks words that must never be programmed. A request to such a word sets a sticky error flag, and that flag blocks all further requests until software clears it.

The controller is one state machine with six states:
- **IDLE** goes to READ on an accepted request, or to RELOAD when a reload is pending.
- **READ** goes to BURN when the read window ends. At that point the request is masked with the read-back word.
- **BURN** goes to RELAX when the strobe window ends.
- **RELAX** goes back to BURN for the next bit, or to SETTLE after bit 31. The data shifts right on leaving RELAX.
- **SETTLE** goes to IDLE when the gap ends.
- **RELOAD** goes to IDLE when its read window ends.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After reset the control register reads 0, the timing register reads 0x0002_100A, the data register reads 0, and fuse_prog and fuse_rd are low.
- R2: Control bits are laid out as follows: the address is in [7:0], BUSY in 8, ERROR in 9, the reload request in 10 and the key in [31:16]. The key value 0x3E77 arms one program. A data-slot write in IDLE with the key armed and ERROR clear shows BUSY on the next cycle and clears the key. A data-slot write without the key stores the value and starts nothing.
- R3: The block burns only the bits that are 1 in the written data and 0 in the fuse word read back, issuing one strobe per such bit.
- R4: Bits are burned least significant first, with increasing fuse_bit_pos. Data shifts right with zero fill, so the data register reads 0 after a burn.
- R5: The fuse address is captured when a program starts. Control-address writes during the burn do not affect the word being programmed.
- R6: While BUSY is set, data-slot and timing-slot writes are ignored.
- R7: A program request to a word whose lock_mask bit is 1, or whose address is at or above NWORDS, sets ERROR, leaves BUSY clear, issues no strobe and still clears the key.
- R8: ERROR is sticky. While it is set, program and reload requests are refused. Only writing bit 9 through the clear alias (slot 2) clears it.
- R9: The timing register holds the strobe width in [11:0], the relax gap in [15:12] and the read window in [21:16]. fuse_rd stays high for the read-window count of cycles, and each fuse_prog pulse lasts the strobe-width count of cycles. A count of 0 counts as 1. Strobes are separated by relax+1 cycles.
- R10: For SETTLE_CYC cycles after BUSY clears at the end of a burn, BUSY stays clear and data-slot writes are ignored.
- R11: The set alias (slot 1) ORs the written value into the address, key, ERROR and reload fields. The clear alias (slot 2) AND-NOTs it into the address, key and ERROR fields. Neither alias affects BUSY.
- R12: Setting the reload bit while ERROR is clear makes the block busy, with fuse_rd high for the read-window count. The reload bit reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register slot: 0 control, 1 set alias, 2 clear alias, 3 timing, 4 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected slot (combinational) |
| lock_mask | input | NWORDS | One bit per word; 1 forbids programming |
| fuse_addr | output | 8 | Latched word address of the current operation |
| fuse_bit_pos | output | 5 | Bit position being programmed |
| fuse_bit | output | 1 | Value of the bit being presented |
| fuse_prog | output | 1 | Program strobe |
| fuse_rd | output | 1 | Read request for the word at fuse_addr |
| fuse_rdata | input | 32 | Read-back word from the array |

## Verification
Each result has a fixed due cycle:
- BUSY and ERROR from a data-slot write are visible in the cycle after the write edge.
- A reload shows BUSY one cycle later than that, because it passes through IDLE first.
- Strobe and read widths are exact counts taken from the timing register.

The bench drives each write on a falling edge and samples in the following low phase. This means every status check lands on the first cycle in which the result is due. Strobe widths, pulse counts and burn order are measured by a monitor that counts every cycle of fuse_prog and fuse_rd. A near-exhaustive sweep programs all 32 words twice with computed patterns and compares the modelled fuse cells against the OR of the requests. It also compares the strobe count against the popcount of the newly set bits.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_BURN,
        S_RELAX,
        S_SETTLE,
        S_RELOAD
    } otp_state_t;

    localparam logic [2:0]  RA_CTRL = 3'd0;
    localparam logic [2:0]  RA_SET  = 3'd1;
    localparam logic [2:0]  RA_CLR  = 3'd2;
    localparam logic [2:0]  RA_TIM  = 3'd3;
    localparam logic [2:0]  RA_DATA = 3'd4;

    localparam int          BIT_BUSY   = 8;
    localparam int          BIT_ERR    = 9;
    localparam int          BIT_RELOAD = 10;

    localparam logic [15:0] ARM_KEY      = 16'h3E77;
    localparam logic [31:0] TIMING_RESET = 32'h0002_100A;
endpackage

// File: rtl/otp_cycle_timer.sv
module otp_cycle_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] len,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (len == '0) ? '0 : len - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/otp_data_shifter.sv
module otp_data_shifter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          mask,
    input  logic [DW-1:0] mask_val,
    input  logic          shift,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (mask)
            q <= q & ~mask_val;
        else if (shift)
            q <= {1'b0, q[DW-1:1]};
    end
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
    import otp_pkg::*;
#(
    parameter int NWORDS     = 32,
    parameter int SETTLE_CYC = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NWORDS-1:0] lock_mask,
    output logic [7:0]        fuse_addr,
    output logic [4:0]        fuse_bit_pos,
    output logic              fuse_bit,
    output logic              fuse_prog,
    output logic              fuse_rd,
    input  logic [31:0]       fuse_rdata
);
    localparam int LW = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int TW = (SW > 12) ? SW : 12;

    otp_state_t state, state_nx;

    logic [7:0]  ctrl_addr, op_addr;
    logic [15:0] ctrl_key;
    logic        ctrl_err, ctrl_reload;
    logic [11:0] tim_sp;
    logic [3:0]  tim_relax;
    logic [5:0]  tim_sr;
    logic [4:0]  bit_cnt;
    logic [31:0] data_q;

    logic          busy, settling, armed, locked;
    logic          wr_ctrl, wr_set, wr_clr, wr_tim, wr_data;
    logic          req_prog, start_burn, lock_err, data_load;
    logic          tmr_load, tmr_done, do_mask, do_shift, reload_done;
    logic [TW-1:0] tmr_len;

    assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
    assign wr_set  = bus_wr && (bus_addr == RA_SET);
    assign wr_clr  = bus_wr && (bus_addr == RA_CLR);
    assign wr_tim  = bus_wr && (bus_addr == RA_TIM);
    assign wr_data = bus_wr && (bus_addr == RA_DATA);

    assign busy       = (state == S_READ) || (state == S_BURN) ||
                        (state == S_RELAX) || (state == S_RELOAD);
    assign settling   = (state == S_SETTLE);
    assign armed      = (ctrl_key == ARM_KEY);
    assign locked     = (int'(ctrl_addr) >= NWORDS) || lock_mask[ctrl_addr[LW-1:0]];
    assign data_load  = wr_data && (state == S_IDLE) && !ctrl_err;
    assign req_prog   = data_load && armed;
    assign start_burn = req_prog && !locked;
    assign lock_err   = req_prog && locked;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next state and sequencing controls
    always_comb begin
        state_nx    = state;
        tmr_load    = 1'b0;
        tmr_len     = '0;
        do_mask     = 1'b0;
        do_shift    = 1'b0;
        reload_done = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start_burn) begin
                    state_nx = S_READ;
                    tmr_load = 1'b1;
                    tmr_len  = TW'(tim_sr);
                end else if (ctrl_reload) begin
                    state_nx = S_RELOAD;
                    tmr_load = 1'b1;
                    tmr_len  = TW'(tim_sr);
                end
            end
            S_READ: if (tmr_done) begin
                state_nx = S_BURN;
                do_mask  = 1'b1;
                tmr_load = 1'b1;
                tmr_len  = TW'(tim_sp);
            end
            S_BURN: if (tmr_done) begin
                state_nx = S_RELAX;
                tmr_load = 1'b1;
                tmr_len  = TW'(tim_relax) + 1'b1;
            end
            S_RELAX: if (tmr_done) begin
                do_shift = 1'b1;
                tmr_load = 1'b1;
                if (bit_cnt == 5'd31) begin
                    state_nx = S_SETTLE;
                    tmr_len  = TW'(SETTLE_CYC);
                end else begin
                    state_nx = S_BURN;
                    tmr_len  = TW'(tim_sp);
                end
            end
            S_SETTLE: if (tmr_done) state_nx = S_IDLE;
            S_RELOAD: if (tmr_done) begin
                state_nx    = S_IDLE;
                reload_done = 1'b1;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // Fuse-side outputs
    always_comb begin
        fuse_rd      = (state == S_READ) || (state == S_RELOAD);
        fuse_prog    = (state == S_BURN) && data_q[0];
        fuse_bit     = ((state == S_BURN) || (state == S_RELAX)) && data_q[0];
        fuse_addr    = op_addr;
        fuse_bit_pos = bit_cnt;
    end

    // Control and timing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_addr   <= '0;
            ctrl_key    <= '0;
            ctrl_err    <= 1'b0;
            ctrl_reload <= 1'b0;
            tim_sp      <= TIMING_RESET[11:0];
            tim_relax   <= TIMING_RESET[15:12];
            tim_sr      <= TIMING_RESET[21:16];
            op_addr     <= '0;
            bit_cnt     <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_addr <= bus_wdata[7:0];
                ctrl_key  <= bus_wdata[31:16];
                if (bus_wdata[BIT_RELOAD] && !ctrl_err && !busy) ctrl_reload <= 1'b1;
            end
            if (wr_set) begin
                ctrl_addr <= ctrl_addr | bus_wdata[7:0];
                ctrl_key  <= ctrl_key | bus_wdata[31:16];
                if (bus_wdata[BIT_ERR]) ctrl_err <= 1'b1;
                if (bus_wdata[BIT_RELOAD] && !ctrl_err && !busy) ctrl_reload <= 1'b1;
            end
            if (wr_clr) begin
                ctrl_addr <= ctrl_addr & ~bus_wdata[7:0];
                ctrl_key  <= ctrl_key & ~bus_wdata[31:16];
                if (bus_wdata[BIT_ERR]) ctrl_err <= 1'b0;
            end
            if (wr_tim && !busy) begin
                tim_sp    <= bus_wdata[11:0];
                tim_relax <= bus_wdata[15:12];
                tim_sr    <= bus_wdata[21:16];
            end
            if (req_prog)    ctrl_key    <= '0;
            if (lock_err)    ctrl_err    <= 1'b1;
            if (reload_done) ctrl_reload <= 1'b0;
            if (start_burn) begin
                op_addr <= ctrl_addr;
                bit_cnt <= '0;
            end else if (do_shift) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    otp_cycle_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .done  (tmr_done)
    );

    otp_data_shifter #(.DW(32)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (data_load),
        .load_val (bus_wdata),
        .mask     (do_mask),
        .mask_val (fuse_rdata),
        .shift    (do_shift),
        .q        (data_q)
    );

    // Register read mux
    always_comb begin
        unique case (bus_addr)
            RA_CTRL, RA_SET, RA_CLR:
                bus_rdata = {ctrl_key, 5'd0, ctrl_reload, ctrl_err, busy, ctrl_addr};
            RA_TIM:  bus_rdata = {10'd0, tim_sr, tim_relax, tim_sp};
            RA_DATA: bus_rdata = data_q;
            default: bus_rdata = '0;
        endcase
    end

    logic unused_settle;
    assign unused_settle = settling;
endmodule

// File: rtl/otp_prog_ctrl_chk.sv
module otp_prog_ctrl_chk
    import otp_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        busy,
    input logic        err,
    input logic [7:0]  fuse_addr,
    input logic [4:0]  fuse_bit_pos,
    input logic        fuse_prog,
    input logic        fuse_rd
);
    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(fuse_addr));

    // R9
    no_rd_prog_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fuse_prog && fuse_rd));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err && !(bus_wr && bus_addr == RA_CLR && bus_wdata[BIT_ERR]) |=> err);

    // R7
    lock_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) && !$past(bus_wr && bus_addr == RA_SET) |-> !busy);

    // R4
    bitpos_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_prog && $past(fuse_prog) |-> $stable(fuse_bit_pos));

    // R6
    prog_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_prog |-> busy);
endmodule

bind otp_prog_ctrl otp_prog_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .busy         (busy),
    .err          (ctrl_err),
    .fuse_addr    (fuse_addr),
    .fuse_bit_pos (fuse_bit_pos),
    .fuse_prog    (fuse_prog),
    .fuse_rd      (fuse_rd)
);

// File: tb/tb_otp_prog_ctrl.sv
module tb_otp_prog_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NW         = 32;
    localparam int SETTLE     = 200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = 3'd0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NW-1:0] lock_mask = '0;
    logic [7:0]    fuse_addr;
    logic [4:0]    fuse_bit_pos;
    logic          fuse_bit, fuse_prog, fuse_rd;
    logic [31:0]   fuse_rdata;

    logic [31:0] fuse_mem [NW];
    logic [31:0] exp_mem  [NW];

    int checks = 0, fails = 0;
    int pulses = 0, rd_cycles = 0, width_bad = 0, order_bad = 0;
    int run = 0, prev_pos = -1, exp_sp = 10;
    logic prev_prog = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_prog_ctrl #(.NWORDS(NW), .SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_mask(lock_mask),
        .fuse_addr(fuse_addr), .fuse_bit_pos(fuse_bit_pos), .fuse_bit(fuse_bit),
        .fuse_prog(fuse_prog), .fuse_rd(fuse_rd), .fuse_rdata(fuse_rdata)
    );

    assign fuse_rdata = fuse_mem[fuse_addr[4:0]];

    // Sticky fuse cell model and strobe monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) fuse_mem[i] <= '0;
        end else begin
            if (fuse_prog) fuse_mem[fuse_addr[4:0]][fuse_bit_pos] <= 1'b1;
            if (fuse_prog) begin
                run = run + 1;
                if (!prev_prog) begin
                    pulses = pulses + 1;
                    if (int'(fuse_bit_pos) <= prev_pos) order_bad = order_bad + 1;
                    prev_pos = int'(fuse_bit_pos);
                end
            end else if (prev_prog) begin
                if (run != exp_sp) width_bad = width_bad + 1;
                run = 0;
            end
            if (fuse_rd) begin
                rd_cycles = rd_cycles + 1;
                prev_pos = -1;
            end
            prev_prog = fuse_prog;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd0, v);
            if (!v[8]) break;
            @(negedge clk);
        end
    endtask

    task automatic clear_mon();
        pulses = 0; rd_cycles = 0; width_bad = 0; order_bad = 0;
    endtask

    // Program one word and check cells, strobe count and final DATA (R3, R4)
    task automatic program_word(input logic [7:0] a, input logic [31:0] val, input string req);
        logic [31:0] v, newbits;
        repeat (SETTLE + 4) @(negedge clk);
        newbits = val & ~exp_mem[a[4:0]];
        clear_mon();
        wr(3'd0, {16'h3E77, 8'h00, a});
        wr(3'd4, val);
        wait_idle();
        exp_mem[a[4:0]] = exp_mem[a[4:0]] | val;
        chk(req, "fuse word", fuse_mem[a[4:0]], exp_mem[a[4:0]]);
        chk("R3", "strobe count", pulses, $countones(newbits));
        rd(3'd4, v);
        chk("R4", "data after burn", v, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, t0, p, q;
        for (int i = 0; i < NW; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); chk("R1", "ctrl reset", v, 32'h0);
        rd(3'd3, v); chk("R1", "timing reset", v, 32'h0002_100A);
        rd(3'd4, v); chk("R1", "data reset", v, 32'h0);
        chk("R1", "strobes idle", {30'd0, fuse_prog, fuse_rd}, 32'h0);

        // R9 timing field layout: strobe 4, relax 1, read 3
        wr(3'd3, 32'h0003_1004);
        exp_sp = 4;
        rd(3'd3, v); chk("R9", "timing write", v, 32'h0003_1004);

        // R2 arming: busy next cycle, key consumed
        clear_mon();
        wr(3'd0, {16'h3E77, 8'h00, 8'd3});
        wr(3'd4, 32'hA5A5_0F0F);
        rd(3'd0, v);
        chk("R2", "busy after data write", {31'd0, v[8]}, 32'd1);
        chk("R2", "key cleared", {16'd0, v[31:16]}, 32'h0);
        wait_idle();
        exp_mem[3] = 32'hA5A5_0F0F;
        chk("R2", "first burn", fuse_mem[3], exp_mem[3]);
        chk("R9", "read window cycles", rd_cycles, 3);
        chk("R9", "strobe width errors", width_bad, 0);
        chk("R4", "order errors", order_bad, 0);
        chk("R3", "strobes first burn", pulses, $countones(32'hA5A5_0F0F));

        // R10 settle: request right after busy clears is ignored
        wr(3'd0, {16'h3E77, 8'h00, 8'd4});
        wr(3'd4, 32'h0000_00F0);
        rd(3'd0, v); chk("R10", "busy in settle", {31'd0, v[8]}, 32'd0);
        rd(3'd4, v); chk("R10", "data ignored in settle", v, 32'h0);
        repeat (SETTLE) @(negedge clk);
        wr(3'd4, 32'h0000_00F0);
        rd(3'd0, v); chk("R10", "accepted after settle", {31'd0, v[8]}, 32'd1);
        wait_idle();
        exp_mem[4] = 32'h0000_00F0;
        chk("R10", "burn after settle", fuse_mem[4], exp_mem[4]);

        // R3 masking against blown bits
        program_word(8'd3, 32'hFFFF_FFFF, "R3");

        // R2 data write without key stores only
        repeat (SETTLE + 4) @(negedge clk);
        clear_mon();
        wr(3'd0, 32'h0000_0006);
        wr(3'd4, 32'h0000_1234);
        rd(3'd0, v); chk("R2", "no key no busy", {31'd0, v[8]}, 32'd0);
        rd(3'd4, v); chk("R2", "data stored", v, 32'h0000_1234);
        repeat (20) @(negedge clk);
        chk("R2", "no key no strobe", pulses, 0);

        // R5, R6: address change, data and timing writes during burn
        repeat (4) @(negedge clk);
        clear_mon();
        rd(3'd3, t0);
        wr(3'd0, {16'h3E77, 8'h00, 8'd7});
        wr(3'd4, 32'h0000_81FF);
        wr(3'd0, 32'h0000_0009);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0003_1009);
        wait_idle();
        exp_mem[7] = exp_mem[7] | 32'h0000_81FF;
        chk("R5", "latched word", fuse_mem[7], exp_mem[7]);
        chk("R5", "other word untouched", fuse_mem[9], exp_mem[9]);
        chk("R6", "data write in busy ignored", pulses, $countones(32'h0000_81FF));
        rd(3'd3, v); chk("R6", "timing write in busy ignored", v, t0);

        // R9 another strobe width
        repeat (SETTLE + 4) @(negedge clk);
        wr(3'd3, 32'h0003_1007);
        exp_sp = 7;
        program_word(8'd10, 32'h0F00_000F, "R9");
        chk("R9", "width 7 errors", width_bad, 0);
        wr(3'd3, 32'h0003_1004);
        exp_sp = 4;

        // R7 locked word
        repeat (SETTLE + 4) @(negedge clk);
        lock_mask[5] = 1'b1;
        clear_mon();
        wr(3'd0, {16'h3E77, 8'h00, 8'd5});
        wr(3'd4, 32'hFFFF_0000);
        rd(3'd0, v);
        chk("R7", "error set", {31'd0, v[9]}, 32'd1);
        chk("R7", "busy clear", {31'd0, v[8]}, 32'd0);
        chk("R7", "key cleared", {16'd0, v[31:16]}, 32'h0);
        repeat (30) @(negedge clk);
        chk("R7", "no strobe", pulses, 0);
        chk("R7", "locked word intact", fuse_mem[5], exp_mem[5]);

        // R8 sticky error refuses program and reload
        wr(3'd0, {16'h3E77, 8'h00, 8'd6});
        wr(3'd4, 32'h0000_0011);
        rd(3'd0, v); chk("R8", "program refused", {31'd0, v[8]}, 32'd0);
        chk("R8", "error held after ctrl write", {31'd0, v[9]}, 32'd1);
        wr(3'd1, 32'h0000_0400);
        @(negedge clk);
        rd(3'd0, v); chk("R8", "reload refused", {30'd0, v[10], v[8]}, 32'd0);
        repeat (20) @(negedge clk);
        chk("R8", "no strobe while error", pulses, 0);
        wr(3'd2, 32'h0000_0200);
        rd(3'd0, v); chk("R8", "error cleared by alias", {31'd0, v[9]}, 32'd0);
        lock_mask[5] = 1'b0;
        program_word(8'd6, 32'h0000_0011, "R8");

        // R2 key consumed: a second write without re-arming starts nothing
        repeat (SETTLE + 4) @(negedge clk);
        wr(3'd4, 32'h0000_0022);
        rd(3'd0, v); chk("R2", "key single use", {31'd0, v[8]}, 32'd0);

        // R11 aliases
        wr(3'd0, 32'h0000_0010);
        wr(3'd1, 32'h0000_0103);
        rd(3'd0, v); chk("R11", "set alias", v, 32'h0000_0013);
        wr(3'd2, 32'h0000_0110);
        rd(3'd0, v); chk("R11", "clear alias", v, 32'h0000_0003);
        wr(3'd1, 32'h3E00_0000);
        wr(3'd1, 32'h0077_0000);
        rd(3'd0, v); chk("R11", "key via set", {16'd0, v[31:16]}, 32'h0000_3E77);
        wr(3'd2, 32'hFFFF_0000);

        // R12 reload
        clear_mon();
        wr(3'd1, 32'h0000_0400);
        @(negedge clk);
        rd(3'd0, v); chk("R12", "busy during reload", {31'd0, v[8]}, 32'd1);
        wait_idle();
        rd(3'd0, v); chk("R12", "reload bit cleared", {31'd0, v[10]}, 32'd0);
        chk("R12", "reload read cycles", rd_cycles, 3);

        // Sweep: every word, two passes with computed patterns (R3, R4)
        for (int i = 0; i < NW; i++) begin
            p = (i * 32'h9E37_79B9) ^ 32'h0000_0005;
            program_word(8'(i), p, "R3");
        end
        clear_mon();
        for (int i = 0; i < NW; i++) begin
            q = {(i * 32'h0101_0101) ^ 32'h8000_0001};
            program_word(8'(i), q, "R4");
        end
        chk("R9", "sweep width errors", width_bad, 0);
        chk("R4", "sweep order errors", order_bad, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule